// File: doc/BRIEF.md
# Management Status and Control Register Bank

This block is a small set of management registers reached through a simple parallel read/write port. The port carries a form select, a 5-bit device code, a 16-bit register address, write data with a write strobe, and a read strobe. The register set holds one read-write control word and one self-clearing command word. The command word turns written ones into one-cycle pulses. The set also holds a live status word, a word of sticky flags that latch high, a word of sticky flags that latch low, and a row of saturating event counters that clear when read.

The same registers answer in two addressing forms. In the long form, the bank responds only to device code 0x1E, and the full 16-bit register address must match. In the short form, only the five low address bits select the register, and the register found is the one whose long address ends in those five bits. Hardware condition inputs feed the sticky flags, and event inputs feed the counters. The serial framing in front of the port lies outside this block.

The map starts at long address 0x0010. Offset 0 is the control word, offset 1 the command word, offset 2 the live status and offset 3 the latch-high flags. Offset 4 holds the latch-low flags, and each counter i sits at offset 5+i. A read returns its data on `rd_data` in the cycle after the read strobe, and the value is held until the next read.

Top module: `mgmt_reg_bank`

## Requirements
- R1: The control word at 0x0010 reads back exactly the value last written to it, and `ctrl_out` drives that value. A write that does not hit the control word leaves it unchanged.
- R2: Writing the command word at 0x0011 raises the written one bits on `cmd_pulse` for exactly the one cycle after the write. Reading 0x0011 always returns 0.
- R3: Reading 0x0012 returns the present `status_in`. Writes to 0x0012, to either sticky word and to any counter are ignored and leave their state unchanged.
- R4: A latch-high flag (0x0013, bit i fed by `lhi_cond[i]`) reads 1 if its condition is active now or was active since the last read of that word. The read clears the flag, and a condition still present reads 1 again on the next read.
- R5: A latch-low flag (0x0014, bit i fed by `llo_cond[i]`) reads 0 if its condition is active now or was active since the last read of that word. The read sets the flag back to 1.
- R6: Counter i (0x0015+i, fed by `cnt_evt[i]`) counts one per cycle in which its event is high and stops at its all-ones maximum. A read returns the count and then clears it.
- R7: In long form (`long_mode`=1), the bank responds only when `dev_addr` is 0x1E and `reg_addr[15:5]` equals 0. Any other access reads 0 and writes nothing.
- R8: In short form (`long_mode`=0), only `reg_addr[4:0]` selects the register, and `dev_addr` and `reg_addr[15:5]` are ignored.
- R9: A read of an unmapped address returns 0 and clears no flag or counter.
- R10: After reset, the control word holds its default (0x0005), latch-high flags and counters are 0, latch-low flags are 1, and `cmd_pulse` and `rd_data` are 0.
- R11: If a condition is active in the same cycle its sticky word is read, the event is kept for the next read. If an event arrives in the same cycle its counter is read, the read returns the old count and the counter restarts at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| long_mode | input | 1 | 1 selects long-form addressing, 0 selects short form |
| dev_addr | input | 5 | Device code, checked in long form only |
| reg_addr | input | 16 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe; read side effects take place in this cycle |
| rd_data | output | 16 | Read data, valid the cycle after `rd_en` and held |
| ctrl_out | output | 16 | Present control word |
| cmd_pulse | output | 16 | One-cycle command pulses |
| status_in | input | 16 | Live status word |
| lhi_cond | input | N_LHI | Conditions for the latch-high flags |
| llo_cond | input | N_LLO | Conditions for the latch-low flags |
| cnt_evt | input | N_CNT | Event inputs, one per counter |

## Verification
The bench goes after the collisions and read side effects. A design where the clear wins over a set would drop a condition raised during the read, so the second read would come back clean. A counter that wraps, or that loses the event arriving on its read cycle, would show 44 instead of 255, or 0 instead of 1. The bench also reads an unmapped address between two reads of a set flag; a decoder that leaks the clear to that address would empty the flag early. It writes through a wrong device code and through a short address with junk upper bits, which catches a long-form check that is too loose and a short-form decode that is too strict.

// File: rtl/mgmt_bank_pkg.sv
package mgmt_bank_pkg;

  localparam logic [4:0]  LONG_DEV_ID = 5'h1E;
  localparam logic [15:0] MAP_BASE    = 16'h0010;
  localparam int unsigned FIXED_SLOTS = 5;

  typedef enum logic [2:0] {
    SLOT_CTRL,
    SLOT_CMD,
    SLOT_STAT,
    SLOT_LHI,
    SLOT_LLO,
    SLOT_CNT
  } slot_kind_e;

  typedef struct packed {
    logic       hit;
    slot_kind_e kind;
    logic [3:0] cnt_idx;
  } slot_t;

  // Offset from the map base to the register kind it selects.
  function automatic slot_t map_offset(input logic [4:0] off, input int unsigned n_cnt);
    slot_t s;
    s.hit     = 1'b1;
    s.kind    = SLOT_CTRL;
    s.cnt_idx = '0;
    case (off)
      5'd0: s.kind = SLOT_CTRL;
      5'd1: s.kind = SLOT_CMD;
      5'd2: s.kind = SLOT_STAT;
      5'd3: s.kind = SLOT_LHI;
      5'd4: s.kind = SLOT_LLO;
      default: begin
        if (int'(off) < int'(FIXED_SLOTS + n_cnt)) begin
          s.kind    = SLOT_CNT;
          s.cnt_idx = 4'(off - 5'(FIXED_SLOTS));
        end else begin
          s.hit = 1'b0;
        end
      end
    endcase
    return s;
  endfunction

  // Saturating step of an event counter with clear on read.
  function automatic logic [15:0] sat_step(input logic [15:0] cur, input logic [15:0] max,
                                           input logic evt, input logic clr);
    if (clr)
      return evt ? 16'd1 : 16'd0;
    else if (evt && cur != max)
      return cur + 16'd1;
    else
      return cur;
  endfunction

endpackage

// File: rtl/mgmt_addr_map.sv
module mgmt_addr_map
  import mgmt_bank_pkg::*;
#(
  parameter int unsigned N_CNT = 2
) (
  input  logic        long_mode,
  input  logic [4:0]  dev_addr,
  input  logic [15:0] reg_addr,
  output slot_t       slot
);

  logic [4:0] offset;
  logic       long_ok;

  assign offset  = reg_addr[4:0] - MAP_BASE[4:0];
  assign long_ok = (dev_addr == LONG_DEV_ID) && (reg_addr[15:5] == MAP_BASE[15:5]);

  always_comb begin
    slot = map_offset(offset, N_CNT);
    if (long_mode && !long_ok)
      slot.hit = 1'b0;
  end

endmodule

// File: rtl/mgmt_sticky.sv
module mgmt_sticky #(
  parameter int unsigned W          = 8,
  parameter bit          ACTIVE_LOW = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cond,
  input  logic         rd_clr,
  output logic [W-1:0] view
);

  // flag is always stored active-high: 1 means an event has been seen.
  logic [W-1:0] flag;
  logic [W-1:0] seen_now;

  assign seen_now = flag | cond;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag <= '0;
    else
      flag <= cond | (flag & {W{~rd_clr}});
  end

  generate
    if (ACTIVE_LOW) begin : g_low
      assign view = ~seen_now;
    end else begin : g_high
      assign view = seen_now;
    end
  endgenerate

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag & $past(cond)) == $past(cond))); // R11
  AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && cond == '0) |=> (flag == '0)); // R4

endmodule

// File: rtl/mgmt_satcnt.sv
module mgmt_satcnt
  import mgmt_bank_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         evt,
  input  logic         rd_clr,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [15:0] next_wide;

  assign next_wide = sat_step(16'(count), 16'(CNT_MAX), evt, rd_clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= '0;
    else
      count <= next_wide[W-1:0];
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_MAX && !rd_clr) |=> (count == CNT_MAX)); // R6
  AST_CLEAR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr |=> (count == W'($past(evt)))); // R11

endmodule

// File: rtl/mgmt_reg_bank.sv
module mgmt_reg_bank
  import mgmt_bank_pkg::*;
#(
  parameter int unsigned N_LHI    = 8,
  parameter int unsigned N_LLO    = 8,
  parameter int unsigned N_CNT    = 2,
  parameter int unsigned CNT_W    = 8,
  parameter logic [15:0] CTRL_RST = 16'h0005
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             long_mode,
  input  logic [4:0]       dev_addr,
  input  logic [15:0]      reg_addr,
  input  logic             wr_en,
  input  logic [15:0]      wr_data,
  input  logic             rd_en,
  output logic [15:0]      rd_data,
  output logic [15:0]      ctrl_out,
  output logic [15:0]      cmd_pulse,
  input  logic [15:0]      status_in,
  input  logic [N_LHI-1:0] lhi_cond,
  input  logic [N_LLO-1:0] llo_cond,
  input  logic [N_CNT-1:0] cnt_evt
);

  slot_t slot;

  logic             wr_ctrl, wr_cmd;
  logic             rd_lhi, rd_llo, rd_miss;
  logic [N_CNT-1:0] rd_cnt;
  logic [N_LHI-1:0] lhi_view;
  logic [N_LLO-1:0] llo_view;
  logic [CNT_W-1:0] cnt_val [N_CNT];
  logic [15:0]      cnt_rd_word [N_CNT];
  logic [15:0]      rd_view;

  mgmt_addr_map #(.N_CNT(N_CNT)) u_map (
    .long_mode (long_mode),
    .dev_addr  (dev_addr),
    .reg_addr  (reg_addr),
    .slot      (slot)
  );

  assign wr_ctrl = wr_en && slot.hit && slot.kind == SLOT_CTRL;
  assign wr_cmd  = wr_en && slot.hit && slot.kind == SLOT_CMD;
  assign rd_lhi  = rd_en && slot.hit && slot.kind == SLOT_LHI;
  assign rd_llo  = rd_en && slot.hit && slot.kind == SLOT_LLO;
  assign rd_miss = rd_en && !slot.hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_out  <= CTRL_RST;
      cmd_pulse <= '0;
    end else begin
      if (wr_ctrl)
        ctrl_out <= wr_data;
      cmd_pulse <= wr_cmd ? wr_data : 16'h0000;
    end
  end

  mgmt_sticky #(.W(N_LHI), .ACTIVE_LOW(1'b0)) u_lhi (
    .clk    (clk),
    .rst_n  (rst_n),
    .cond   (lhi_cond),
    .rd_clr (rd_lhi),
    .view   (lhi_view)
  );

  mgmt_sticky #(.W(N_LLO), .ACTIVE_LOW(1'b1)) u_llo (
    .clk    (clk),
    .rst_n  (rst_n),
    .cond   (llo_cond),
    .rd_clr (rd_llo),
    .view   (llo_view)
  );

  generate
    for (genvar gi = 0; gi < N_CNT; gi++) begin : g_cnt
      assign rd_cnt[gi] = rd_en && slot.hit && slot.kind == SLOT_CNT
                          && slot.cnt_idx == 4'(gi);
      mgmt_satcnt #(.W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (cnt_evt[gi]),
        .rd_clr (rd_cnt[gi]),
        .count  (cnt_val[gi])
      );
      assign cnt_rd_word[gi] = slot.cnt_idx == 4'(gi) ? 16'(cnt_val[gi]) : 16'h0000;
    end
  endgenerate

  always_comb begin
    rd_view = 16'h0000;
    if (slot.hit) begin
      case (slot.kind)
        SLOT_CTRL: rd_view = ctrl_out;
        SLOT_STAT: rd_view = status_in;
        SLOT_LHI:  rd_view = 16'(lhi_view);
        SLOT_LLO:  rd_view = 16'(llo_view);
        SLOT_CNT:  for (int i = 0; i < N_CNT; i++) rd_view = rd_view | cnt_rd_word[i];
        default:   rd_view = 16'h0000;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rd_data <= '0;
    else if (rd_en)
      rd_data <= rd_view;
  end

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(ctrl_out)); // R1
  AST_PULSE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_pulse != 16'h0000) |-> $past(wr_cmd)); // R2
  AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_miss |=> (rd_data == 16'h0000)); // R9
  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data)); // R10

endmodule

// File: tb/mgmt_reg_bank_bench.sv
module mgmt_reg_bank_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        long_mode = 1'b1;
  logic [4:0]  dev_addr = 5'h1E;
  logic [15:0] reg_addr = '0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_data, ctrl_out, cmd_pulse;
  logic [15:0] status_in = '0;
  logic [7:0]  lhi_cond = '0;
  logic [7:0]  llo_cond = '0;
  logic [1:0]  cnt_evt = '0;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  mgmt_reg_bank u_mgmt_reg_bank (
    .clk(clk), .rst_n(rst_n), .long_mode(long_mode), .dev_addr(dev_addr),
    .reg_addr(reg_addr), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .ctrl_out(ctrl_out), .cmd_pulse(cmd_pulse),
    .status_in(status_in), .lhi_cond(lhi_cond), .llo_cond(llo_cond),
    .cnt_evt(cnt_evt)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic mwrite(input logic lm, input logic [4:0] dv, input logic [15:0] a,
                        input logic [15:0] d);
    @(negedge clk);
    long_mode = lm; dev_addr = dv; reg_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic mread(input logic lm, input logic [4:0] dv, input logic [15:0] a,
                       output logic [15:0] d);
    @(negedge clk);
    long_mode = lm; dev_addr = dv; reg_addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  // entry: {is_read, long_mode, dev, addr, data, req}
  localparam int NV = 13;
  localparam logic [42:0] VEC [NV] = '{
    {1'b1, 1'b1, 5'h1E, 16'h0010, 16'h0005, 4'd10}, // R10 default
    {1'b0, 1'b1, 5'h1E, 16'h0010, 16'hA5C3, 4'd1},
    {1'b1, 1'b1, 5'h1E, 16'h0010, 16'hA5C3, 4'd1},  // R1
    {1'b0, 1'b1, 5'h1D, 16'h0010, 16'hFFFF, 4'd7},  // R7 wrong device
    {1'b1, 1'b0, 5'h00, 16'h0010, 16'hA5C3, 4'd8},  // R8
    {1'b0, 1'b0, 5'h03, 16'h7F10, 16'h1234, 4'd8},  // R8 upper bits ignored
    {1'b1, 1'b1, 5'h1E, 16'h0010, 16'h1234, 4'd8},
    {1'b1, 1'b1, 5'h1E, 16'h0011, 16'h0000, 4'd2},  // R2 reads 0
    {1'b1, 1'b1, 5'h1E, 16'h0030, 16'h0000, 4'd7},  // R7 upper mismatch
    {1'b1, 1'b1, 5'h1E, 16'h001F, 16'h0000, 4'd9},  // R9
    {1'b1, 1'b1, 5'h1D, 16'h0010, 16'h0000, 4'd7},  // R7
    {1'b0, 1'b1, 5'h1E, 16'h0012, 16'hFFFF, 4'd3},
    {1'b1, 1'b1, 5'h1E, 16'h0012, 16'h3C5A, 4'd3}   // R3
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] d;
    status_in = 16'h3C5A;
    repeat (3) @(negedge clk);
    check("R10 rd_data", rd_data, 16'h0000);
    check("R10 cmd_pulse", cmd_pulse, 16'h0000);
    check("R10 ctrl_out", ctrl_out, 16'h0005);
    rst_n = 1'b1;
    mread(1'b1, 5'h1E, 16'h0013, d); check("R10 lhi reset", d, 16'h0000);
    mread(1'b1, 5'h1E, 16'h0014, d); check("R10 llo reset", d, 16'h00FF);
    mread(1'b1, 5'h1E, 16'h0015, d); check("R10 counter reset", d, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      logic [42:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v[3:0], i);
      if (v[42]) begin
        mread(v[41], v[40:36], v[35:20], d);
        check(tag, d, v[19:4]);
      end else begin
        mwrite(v[41], v[40:36], v[35:20], v[19:4]);
      end
    end
    check("R1 ctrl_out", ctrl_out, 16'h1234);

    // R11 rd_data held between reads
    repeat (3) @(negedge clk);
    check("R11 rd_data held", rd_data, 16'h3C5A);

    // R2 command pulse lasts one cycle
    mwrite(1'b1, 5'h1E, 16'h0011, 16'h0081);
    check("R2 pulse high", cmd_pulse, 16'h0081);
    @(negedge clk);
    check("R2 pulse gone", cmd_pulse, 16'h0000);
    check("R2 ctrl untouched", ctrl_out, 16'h1234);

    // R4 latch high, past event
    @(negedge clk); lhi_cond = 8'h04; @(negedge clk); lhi_cond = 8'h00;
    mwrite(1'b1, 5'h1E, 16'h0013, 16'h0000); // R3 write ignored
    mread(1'b1, 5'h1E, 16'h001F, d);         // R9 no side effect
    mread(1'b1, 5'h1E, 16'h0013, d); check("R4 lhi latched", d, 16'h0004);
    mread(1'b1, 5'h1E, 16'h0013, d); check("R4 lhi cleared", d, 16'h0000);
    // R4 ongoing condition
    lhi_cond = 8'h10;
    mread(1'b1, 5'h1E, 16'h0013, d); check("R4 lhi ongoing 1", d, 16'h0010);
    mread(1'b1, 5'h1E, 16'h0013, d); check("R4 lhi ongoing 2", d, 16'h0010);
    lhi_cond = 8'h00;
    mread(1'b1, 5'h1E, 16'h0013, d); check("R4 lhi after drop", d, 16'h0010);
    mread(1'b1, 5'h1E, 16'h0013, d); check("R4 lhi clean", d, 16'h0000);
    // R11 condition during read cycle is kept
    @(negedge clk);
    reg_addr = 16'h0013; rd_en = 1'b1; lhi_cond = 8'h20;
    @(negedge clk);
    rd_en = 1'b0; lhi_cond = 8'h00;
    check("R11 lhi read with set", rd_data, 16'h0020);
    mread(1'b1, 5'h1E, 16'h0013, d); check("R11 lhi kept", d, 16'h0020);

    // R5 latch low
    @(negedge clk); llo_cond = 8'h02; @(negedge clk); llo_cond = 8'h00;
    mread(1'b1, 5'h1E, 16'h0014, d); check("R5 llo latched", d, 16'h00FD);
    mread(1'b1, 5'h1E, 16'h0014, d); check("R5 llo restored", d, 16'h00FF);
    @(negedge clk);
    reg_addr = 16'h0014; rd_en = 1'b1; llo_cond = 8'h80;
    @(negedge clk);
    rd_en = 1'b0; llo_cond = 8'h00;
    check("R11 llo read with set", rd_data, 16'h007F);
    mread(1'b1, 5'h1E, 16'h0014, d); check("R11 llo kept", d, 16'h007F);

    // R6 counting and clear on read
    @(negedge clk); cnt_evt = 2'b10;
    repeat (5) @(negedge clk);
    cnt_evt = 2'b00;
    mwrite(1'b1, 5'h1E, 16'h0016, 16'h00AA); // R3 ignored
    mread(1'b1, 5'h1E, 16'h0016, d); check("R6 count 5", d, 16'h0005);
    mread(1'b1, 5'h1E, 16'h0016, d); check("R6 cleared", d, 16'h0000);
    mread(1'b1, 5'h1E, 16'h0015, d); check("R6 other counter", d, 16'h0000);
    // R6 saturation
    @(negedge clk); cnt_evt = 2'b01;
    repeat (300) @(negedge clk);
    cnt_evt = 2'b00;
    mread(1'b0, 5'h00, 16'h0015, d); check("R6 saturated", d, 16'h00FF);
    // R11 event on the read cycle
    @(negedge clk); cnt_evt = 2'b01; @(negedge clk); cnt_evt = 2'b00;
    @(negedge clk);
    long_mode = 1'b1; dev_addr = 5'h1E; reg_addr = 16'h0015; rd_en = 1'b1; cnt_evt = 2'b01;
    @(negedge clk);
    rd_en = 1'b0; cnt_evt = 2'b00;
    check("R11 count before clear", rd_data, 16'h0001);
    mread(1'b1, 5'h1E, 16'h0015, d); check("R11 restart at 1", d, 16'h0001);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule